// File: doc/BRIEF.md
# Uncorrectable/Correctable Error Status Logger with First-Error Tracking

This block holds the two error status registers of a memory-attached link device and turns error events into interrupt requests. Correctable events are kept as plain sticky bits that software clears by writing ones. Uncorrectable events are kept as individual records in an ordered queue, so that several errors of any type can each keep their own captured header. A pointer names the type of the oldest record, and a header log shows that record's header, so software always sees the oldest outstanding error first.

Software acknowledges uncorrectable errors through a single status write. Writing exactly the bit the pointer names retires only the oldest record. The pointer and header log then move on to the next record. Any other non-zero pattern purges every queued record whose type bit is set. Each mask register stops the matching event types from entering the block at all. The event side marks the last event of an injection batch. A batch that leaves uncorrectable status behind produces one interrupt pulse.

Top module: `ras_err_logger`

## Requirements
- R1: An event whose type bit is set in its mask input (`unc_mask` for uncorrectable events, `cor_mask` for correctable ones) is ignored. It changes no status bit and queues no record. A masked correctable event raises no `irq_cor`.
- R2: Each unmasked uncorrectable event is appended to the queue behind all earlier records. The record keeps the event's type and its `HDR_DWORDS`-dword header, and is visible from the clock edge that accepts it.
- R3: `unc_status` bit t is 1 exactly when at least one queued record has type t. Bits at or above `UNC_TYPES` read 0.
- R4: `first_err_ptr` holds the type of the oldest queued record and `hdr_log` holds that record's header. Header dword k occupies bits [32k+31:32k]. When the queue is empty, `first_err_ptr` reads `STAT_W-1` (31, a bit no error type uses) and `hdr_log` reads all zeros.
- R5: A write with `wr_sel`=0 whose data equals exactly 1 << `first_err_ptr` removes only the oldest record. This holds even when later records have the same type.
- R6: A write with `wr_sel`=0 and any other non-zero data removes every queued record whose type bit is set in the data. A zero write changes nothing. A write of 1 << 31 to an empty queue also changes nothing.
- R7: A write with `wr_sel`=1 clears each `cor_status` bit that is 1 in the data. When an unmasked correctable event of the same type arrives in that cycle, the set wins.
- R8: An unmasked correctable event of type 0 to 6 sets its `cor_status` bit. It also gives a one-cycle `irq_cor` pulse in the cycle after the accepting edge. A type of 7 is ignored.
- R9: `irq_unc` pulses for one cycle after the edge that accepts an uncorrectable event with `unc_evt_last`=1, and only when `unc_status` is then non-zero. No pulse follows events with `unc_evt_last`=0.
- R10: An unmasked uncorrectable event that finds all `DEPTH` entries occupied is dropped and sets `unc_overflow`. The flag stays set until reset.
- R11: After a synchronous active-low reset, both status registers read 0. `first_err_ptr` reads 31, `hdr_log` reads 0, and `unc_overflow`, `irq_unc` and `irq_cor` read 0.
- R12: When a status write and an uncorrectable event share a cycle, the removal acts on the records already queued, and the new event is appended afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unc_evt_valid | input | 1 | Uncorrectable event present this cycle |
| unc_evt_last | input | 1 | Event closes an injection batch |
| unc_evt_type | input | 4 | Uncorrectable error type code |
| unc_evt_hdr | input | HDR_DWORDS*32 | Captured header of the event |
| unc_mask | input | STAT_W | Uncorrectable type mask, 1 = ignore |
| cor_evt_valid | input | 1 | Correctable event present this cycle |
| cor_evt_type | input | 3 | Correctable error type code |
| cor_mask | input | STAT_W | Correctable type mask, 1 = ignore |
| wr_en | input | 1 | Software status write strobe |
| wr_sel | input | 1 | 0 = uncorrectable status, 1 = correctable status |
| wr_data | input | STAT_W | Write data |
| unc_status | output | STAT_W | Uncorrectable status |
| first_err_ptr | output | 5 | Type of oldest queued record |
| hdr_log | output | HDR_DWORDS*32 | Header of oldest queued record |
| cor_status | output | STAT_W | Correctable status |
| unc_overflow | output | 1 | Sticky queue-full drop flag |
| irq_unc | output | 1 | Uncorrectable interrupt pulse |
| irq_cor | output | 1 | Correctable interrupt pulse |

## Verification
A queue that loses its order or leaves a gap shows up as a wrong `first_err_ptr` or `hdr_log`. This is seen at the first exact-bit acknowledge after the fault, one cycle after the write edge. A wrong choice between retire and purge shows at once in `unc_status` and the pointer, and so does a misapplied mask. A write-versus-event ordering fault is exposed by the shared-cycle purge case, where the wrong order leaves an empty queue instead of the new record. A stale correctable set/clear resolution appears in `cor_status` in the same cycle.

// File: rtl/ras_log_pkg.sv
// Shared definitions for the error status logger.
// Assumes: wr_sel is a single bit choosing which status register a write hits.
package ras_log_pkg;
    typedef enum logic {
        TGT_UNC = 1'b0,
        TGT_COR = 1'b1
    } wr_tgt_e;
endpackage

// File: rtl/unc_rec_queue.sv
// Ordered queue of uncorrectable error records with retire/purge removal.
// Entry 0 is always the oldest record; valid entries stay packed from 0.
// Assumes: rm_en is only asserted with non-zero rm_data.
module unc_rec_queue #(
    parameter int DEPTH  = 8,
    parameter int UT_W   = 4,
    parameter int HDR_W  = 128,
    parameter int STAT_W = 32,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_en,
    input  logic [UT_W-1:0]   app_typ,
    input  logic [HDR_W-1:0]  app_hdr,
    input  logic              rm_en,
    input  logic [STAT_W-1:0] rm_data,
    output logic [STAT_W-1:0] status,
    output logic [PTR_W-1:0]  head_ptr,
    output logic [HDR_W-1:0]  head_hdr,
    output logic              ovf
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int UNUSED = STAT_W - 1;

    logic [DEPTH-1:0] q_vld, n_vld, keep;
    logic [UT_W-1:0]  q_typ [DEPTH];
    logic [UT_W-1:0]  n_typ [DEPTH];
    logic [HDR_W-1:0] q_hdr [DEPTH];
    logic [HDR_W-1:0] n_hdr [DEPTH];
    logic             exact, ovf_set;
    logic [CNT_W-1:0] fill;

    // Decide which existing records survive this cycle's write.
    always_comb begin
        exact = q_vld[0] && (rm_data == (STAT_W'(1) << q_typ[0]));
        for (int i = 0; i < DEPTH; i++) begin
            keep[i] = q_vld[i] && !(rm_en && (exact ? (i == 0) : rm_data[q_typ[i]]));
        end
    end

    // Compact survivors toward entry 0, then append the new record.
    always_comb begin
        n_vld   = '0;
        fill    = '0;
        ovf_set = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            n_typ[i] = '0;
            n_hdr[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                n_vld[fill[IDX_W-1:0]] = 1'b1;
                n_typ[fill[IDX_W-1:0]] = q_typ[i];
                n_hdr[fill[IDX_W-1:0]] = q_hdr[i];
                fill = fill + CNT_W'(1);
            end
        end
        if (app_en) begin
            if (fill < CNT_W'(DEPTH)) begin
                n_vld[fill[IDX_W-1:0]] = 1'b1;
                n_typ[fill[IDX_W-1:0]] = app_typ;
                n_hdr[fill[IDX_W-1:0]] = app_hdr;
            end else begin
                ovf_set = 1'b1;
            end
        end
    end

    // Queue storage and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= '0;
            ovf   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                q_typ[i] <= '0;
                q_hdr[i] <= '0;
            end
        end else begin
            q_vld <= n_vld;
            ovf   <= ovf | ovf_set;
            for (int i = 0; i < DEPTH; i++) begin
                q_typ[i] <= n_typ[i];
                q_hdr[i] <= n_hdr[i];
            end
        end
    end

    // Status is the union of type bits over all queued records.
    always_comb begin
        status = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (q_vld[i]) status[q_typ[i]] = 1'b1;
        end
    end

    // Oldest record drives pointer and header log.
    always_comb begin
        head_ptr = q_vld[0] ? PTR_W'(q_typ[0]) : PTR_W'(UNUSED);
        head_hdr = q_vld[0] ? q_hdr[0] : '0;
    end

    generate
        for (genvar g = 0; g < DEPTH - 1; g++) begin : g_contig
            // R2
            packed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q_vld[g+1] |-> q_vld[g]);
        end
    endgenerate

    // R10
    no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R2
    append_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_en && !rm_en && !q_vld[DEPTH-1] |=> status[$past(app_typ)]);

    // R6
    purge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en && !app_en && (rm_data != (STAT_W'(1) << head_ptr))
        |=> ((status & $past(rm_data)) == '0));
endmodule

// File: rtl/cor_w1c_status.sv
// Correctable error status: write-one-to-clear bits with an interrupt pulse
// for each accepted event. A same-cycle set beats a clear of the same bit.
// Assumes: type codes at or above COR_TYPES are not valid errors.
module cor_w1c_status #(
    parameter int STAT_W    = 32,
    parameter int COR_TYPES = 7,
    parameter int CT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CT_W-1:0]   ev_typ,
    input  logic [STAT_W-1:0] mask,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic              ev_ok;
    logic [STAT_W-1:0] set_vec;

    // Qualify the event against range and mask.
    always_comb begin
        ev_ok   = ev_valid && (int'(ev_typ) < COR_TYPES) && !mask[ev_typ];
        set_vec = '0;
        if (ev_ok) set_vec[ev_typ] = 1'b1;
    end

    // Status register update and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (clr_en ? (status & ~clr_data) : status) | set_vec;
            irq    <= ev_ok;
        end
    end

    // R8
    cor_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> status[$past(ev_typ)] && irq);

    // R7
    cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && !ev_valid |=> ((status & $past(clr_data)) == '0));

    // R1
    cor_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && mask[ev_typ] && !clr_en |=> $stable(status) && !irq);
endmodule

// File: rtl/ras_err_logger.sv
// Top of the error status logger: routes events and software writes to the
// uncorrectable record queue and the correctable status register, and forms
// the per-batch uncorrectable interrupt.
// Assumes: one event of each class at most per cycle; masks are quasi-static.
module ras_err_logger #(
    parameter int DEPTH      = 8,
    parameter int HDR_DWORDS = 4,
    parameter int UNC_TYPES  = 16,
    parameter int COR_TYPES  = 7,
    parameter int STAT_W     = 32,
    localparam int HDR_W     = HDR_DWORDS * 32,
    localparam int UT_W      = $clog2(UNC_TYPES),
    localparam int CT_W      = $clog2(COR_TYPES),
    localparam int PTR_W     = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unc_evt_valid,
    input  logic              unc_evt_last,
    input  logic [UT_W-1:0]   unc_evt_type,
    input  logic [HDR_W-1:0]  unc_evt_hdr,
    input  logic [STAT_W-1:0] unc_mask,
    input  logic              cor_evt_valid,
    input  logic [CT_W-1:0]   cor_evt_type,
    input  logic [STAT_W-1:0] cor_mask,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] unc_status,
    output logic [PTR_W-1:0]  first_err_ptr,
    output logic [HDR_W-1:0]  hdr_log,
    output logic [STAT_W-1:0] cor_status,
    output logic              unc_overflow,
    output logic              irq_unc,
    output logic              irq_cor
);
    import ras_log_pkg::*;

    logic unc_app, unc_rm, cor_clr, batch_done_q;

    // Decode events and software writes.
    always_comb begin
        unc_app = unc_evt_valid && !unc_mask[unc_evt_type];
        unc_rm  = wr_en && (wr_sel == TGT_UNC) && (wr_data != '0);
        cor_clr = wr_en && (wr_sel == TGT_COR);
    end

    unc_rec_queue #(
        .DEPTH(DEPTH), .UT_W(UT_W), .HDR_W(HDR_W), .STAT_W(STAT_W), .PTR_W(PTR_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .app_en(unc_app), .app_typ(unc_evt_type), .app_hdr(unc_evt_hdr),
        .rm_en(unc_rm), .rm_data(wr_data),
        .status(unc_status), .head_ptr(first_err_ptr), .head_hdr(hdr_log),
        .ovf(unc_overflow)
    );

    cor_w1c_status #(
        .STAT_W(STAT_W), .COR_TYPES(COR_TYPES), .CT_W(CT_W)
    ) u_cor (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(cor_evt_valid), .ev_typ(cor_evt_type), .mask(cor_mask),
        .clr_en(cor_clr), .clr_data(wr_data),
        .status(cor_status), .irq(irq_cor)
    );

    // Remember that a batch closed on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) batch_done_q <= 1'b0;
        else        batch_done_q <= unc_evt_valid && unc_evt_last;
    end

    // One pulse per closed batch that leaves uncorrectable status behind.
    always_comb irq_unc = batch_done_q && (unc_status != '0);

    // R4
    empty_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_status == '0) |-> (first_err_ptr == PTR_W'(STAT_W - 1)) && (hdr_log == '0));

    // R9
    irq_batch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_unc |-> $past(unc_evt_valid && unc_evt_last));

    // R1
    unc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unc_evt_valid && unc_mask[unc_evt_type] && !unc_rm |=> $stable(unc_status));
endmodule

// File: tb/sim_ras_err_logger.sv
`timescale 1ns/1ps
module sim_ras_err_logger;
    localparam logic [31:0] UMASK = 32'h0000_0200;
    localparam logic [31:0] CMASK = 32'h0000_0020;

    typedef struct packed {
        logic [1:0]  op;   // 0 unc event, 1 unc write, 2 cor event, 3 cor write
        logic [31:0] arg;
        logic [15:0] eu;
        logic [4:0]  ep;
        logic [7:0]  eh;   // header tag of oldest record, 0 = empty
        logic [7:0]  ec;
    } vec_t;

    localparam vec_t TBL [21] = '{
        '{2'd0, 32'd3,          16'h0008, 5'd3,  8'd1,  8'h00},
        '{2'd0, 32'd7,          16'h0088, 5'd3,  8'd1,  8'h00},
        '{2'd0, 32'd9,          16'h0088, 5'd3,  8'd1,  8'h00},
        '{2'd0, 32'd3,          16'h0088, 5'd3,  8'd1,  8'h00},
        '{2'd1, 32'h0000_0008,  16'h0088, 5'd7,  8'd2,  8'h00},
        '{2'd1, 32'h0000_0080,  16'h0008, 5'd3,  8'd4,  8'h00},
        '{2'd0, 32'd12,         16'h1008, 5'd3,  8'd4,  8'h00},
        '{2'd0, 32'd0,          16'h1009, 5'd3,  8'd4,  8'h00},
        '{2'd1, 32'h0000_1001,  16'h0008, 5'd3,  8'd4,  8'h00},
        '{2'd0, 32'd15,         16'h8008, 5'd3,  8'd4,  8'h00},
        '{2'd1, 32'h0000_0000,  16'h8008, 5'd3,  8'd4,  8'h00},
        '{2'd1, 32'h0000_8008,  16'h0000, 5'd31, 8'd0,  8'h00},
        '{2'd1, 32'h8000_0000,  16'h0000, 5'd31, 8'd0,  8'h00},
        '{2'd2, 32'd2,          16'h0000, 5'd31, 8'd0,  8'h04},
        '{2'd2, 32'd5,          16'h0000, 5'd31, 8'd0,  8'h04},
        '{2'd2, 32'd6,          16'h0000, 5'd31, 8'd0,  8'h44},
        '{2'd2, 32'd7,          16'h0000, 5'd31, 8'd0,  8'h44},
        '{2'd3, 32'h0000_0004,  16'h0000, 5'd31, 8'd0,  8'h40},
        '{2'd3, 32'h0000_00FF,  16'h0000, 5'd31, 8'd0,  8'h00},
        '{2'd0, 32'd5,          16'h0020, 5'd5,  8'd20, 8'h00},
        '{2'd1, 32'h0000_0020,  16'h0000, 5'd31, 8'd0,  8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         unc_evt_valid, unc_evt_last, cor_evt_valid, wr_en, wr_sel;
    logic [3:0]   unc_evt_type;
    logic [127:0] unc_evt_hdr;
    logic [2:0]   cor_evt_type;
    logic [31:0]  wr_data;
    logic [31:0]  unc_status, cor_status;
    logic [4:0]   first_err_ptr;
    logic [127:0] hdr_log;
    logic         unc_overflow, irq_unc, irq_cor;
    int           n_chk = 0;
    int           n_bad = 0;

    always #2.5 clk = ~clk;

    ras_err_logger u0 (
        .clk(clk), .rst_n(rst_n),
        .unc_evt_valid(unc_evt_valid), .unc_evt_last(unc_evt_last),
        .unc_evt_type(unc_evt_type), .unc_evt_hdr(unc_evt_hdr), .unc_mask(UMASK),
        .cor_evt_valid(cor_evt_valid), .cor_evt_type(cor_evt_type), .cor_mask(CMASK),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .unc_status(unc_status), .first_err_ptr(first_err_ptr), .hdr_log(hdr_log),
        .cor_status(cor_status), .unc_overflow(unc_overflow),
        .irq_unc(irq_unc), .irq_cor(irq_cor)
    );

    function automatic logic [127:0] mk_hdr(input logic [7:0] tag);
        logic [127:0] h;
        for (int k = 0; k < 4; k++) h[k*32 +: 32] = {16'hE17A, tag, 8'(k)};
        return h;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        unc_evt_valid = 1'b0; unc_evt_last = 1'b0; unc_evt_type = '0; unc_evt_hdr = '0;
        cor_evt_valid = 1'b0; cor_evt_type = '0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    // Hold the driven inputs over one rising edge, then return to idle.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic unc_ev(input logic [3:0] t, input logic [7:0] tag, input logic last);
        unc_evt_valid = 1'b1; unc_evt_type = t; unc_evt_hdr = mk_hdr(tag); unc_evt_last = last;
        tick();
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
    endtask

    task automatic cor_ev(input logic [2:0] t);
        cor_evt_valid = 1'b1; cor_evt_type = t;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string req_of(input logic [1:0] op);
        case (op)
            2'd0:    return "R1 R2 R3 R4 R9";
            2'd1:    return "R5 R6 R4";
            2'd2:    return "R8 R1";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R11 reset state
        chk("R11", "unc_status", unc_status, 0);
        chk("R11", "first_err_ptr", first_err_ptr, 31);
        chk("R11", "hdr_log", hdr_log, 0);
        chk("R11", "cor_status", cor_status, 0);
        chk("R11", "flags", {unc_overflow, irq_unc, irq_cor}, 0);

        // Table walk: one operation per cycle, outputs checked after its edge.
        for (int s = 0; s < 21; s++) begin
            vec_t v;
            string rq;
            logic exp_ic;
            v  = TBL[s];
            rq = req_of(v.op);
            case (v.op)
                2'd0: unc_ev(v.arg[3:0], 8'(s + 1), 1'b1);
                2'd1: wr(1'b0, v.arg);
                2'd2: cor_ev(v.arg[2:0]);
                default: wr(1'b1, v.arg);
            endcase
            exp_ic = (v.op == 2'd2) && (v.arg < 7) && !CMASK[v.arg[4:0]];
            chk(rq, $sformatf("step %0d unc_status", s), unc_status, {16'h0, v.eu});
            chk(rq, $sformatf("step %0d first_err_ptr", s), first_err_ptr, v.ep);
            chk(rq, $sformatf("step %0d hdr_log", s), hdr_log,
                (v.eh == 0) ? 128'h0 : mk_hdr(v.eh));
            chk(rq, $sformatf("step %0d cor_status", s), cor_status, {24'h0, v.ec});
            chk(rq, $sformatf("step %0d irq_unc", s), irq_unc,
                (v.op == 2'd0) && (v.eu != 0));
            chk(rq, $sformatf("step %0d irq_cor", s), irq_cor, exp_ic);
        end

        // R10 fill the queue inside one batch, then overflow.
        do_reset();
        for (int t = 1; t <= 8; t++) begin
            unc_ev(4'(t), 8'(t + 8'h40), t == 8);
            if (t == 1) chk("R9", "no pulse mid-batch", irq_unc, 0);
        end
        chk("R9", "pulse at batch end", irq_unc, 1);
        chk("R3", "full queue status", unc_status, 32'h0000_01FE);
        chk("R4", "full queue pointer", first_err_ptr, 1);
        chk("R10", "no overflow yet", unc_overflow, 0);
        unc_ev(4'd10, 8'h4A, 1'b1);
        chk("R10", "overflow set", unc_overflow, 1);
        chk("R10", "dropped event absent", unc_status, 32'h0000_01FE);
        chk("R4", "head unchanged after drop", hdr_log, mk_hdr(8'h41));
        wr(1'b0, 32'h0000_FFFF);
        chk("R6", "purge all", unc_status, 0);
        chk("R10", "overflow sticky", unc_overflow, 1);
        do_reset();
        @(negedge clk);
        chk("R11", "overflow cleared by reset", unc_overflow, 0);

        // R12 purge and append in the same cycle.
        unc_ev(4'd2, 8'h31, 1'b1);
        unc_ev(4'd6, 8'h32, 1'b1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_0044;
        unc_evt_valid = 1'b1; unc_evt_type = 4'd6; unc_evt_hdr = mk_hdr(8'h33); unc_evt_last = 1'b1;
        tick();
        chk("R12", "status after shared cycle", unc_status, 32'h0000_0040);
        chk("R12", "pointer after shared cycle", first_err_ptr, 6);
        chk("R12", "header after shared cycle", hdr_log, mk_hdr(8'h33));
        chk("R9", "pulse after shared cycle", irq_unc, 1);

        // R7 set beats clear in the same cycle.
        cor_ev(3'd3);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0000_0008;
        cor_evt_valid = 1'b1; cor_evt_type = 3'd3;
        tick();
        chk("R7", "set wins over clear", cor_status, 32'h0000_0008);
        wr(1'b1, 32'h0000_0008);
        chk("R7", "clear alone", cor_status, 0);
        chk("R7", "unc untouched by cor write", unc_status, 32'h0000_0040);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule